// File: doc/BRIEF.md
# Shrinking-Range Pyramid Counter

This block is an up-counter whose terminal value drops by one after every completed pass. Straight after a clear, the count climbs from 0 to 15. It then wraps to 0, and the next pass stops at 14, the one after that at 13, and so on. Once a pass with a terminal value of 0 has finished, the terminal value reloads to 15 and the pyramid starts over. One full pyramid takes 136 enabled cycles.

The counter has two registered strobes:
- `pass_end_o` marks every wrap back to 0.
- `step_one_o` marks every step from 0 to 1.

Both strobes rise in the same cycle in which `count_o` shows the new value.

All control is synchronous to the rising clock edge. The clear input has priority over the enable input. When the enable input is low, the block is frozen. The counter width is a parameter, and its default is 4 bits.

Top module: `pyramid_counter`

## Requirements
- R1: When `clr` is high at a rising edge, the next state is `count_o`=0, with both strobes low and the terminal value set to the maximum (15), whatever `en` is. The next enabled pass therefore runs from 0 to 15.
- R2: The first pass after a clear runs 0,1,...,15 over 16 enabled cycles.
- R3: While the count is below the current terminal value, each enabled edge adds exactly one to `count_o`.
- R4: When the count equals the current terminal value, an enabled edge sets `count_o` to 0. `pass_end_o` is high for exactly that one cycle.
- R5: Each pass is one cycle shorter than the one before it. The pass lengths after a clear are 16, 15, ..., 1.
- R6: After the pass whose terminal value is 0, the terminal value reloads to 15. The following pass runs 0 to 15 again.
- R7: `step_one_o` is high for one cycle exactly when `count_o` has just stepped from 0 to 1, and at no other time.
- R8: The enable is sampled only at the rising edge. An edge with `en` low keeps the count and the terminal value unchanged and drives both strobes low.
- R9: In a pass whose terminal value is 0, the count stays at 0. `pass_end_o` fires on that edge, and `step_one_o` does not.
- R10: `pass_end_o` and `step_one_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear, active high, has priority over `en` |
| en | input | 1 | Synchronous count enable, active high |
| count_o | output | WIDTH | Current count value |
| pass_end_o | output | 1 | One-cycle strobe when the count wraps back to 0 |
| step_one_o | output | 1 | One-cycle strobe when the count steps from 0 to 1 |

## Verification
Some properties are checked by the bound checker on every cycle:
- The count never exceeds the internal terminal value.
- An enabled edge either adds one or wraps to 0 with the end strobe.
- The terminal value drops by one, or reloads from 0 to the maximum.
- An idle edge freezes the count and clears both strobes.
- The two strobes are never high together.

Other behaviour can only be shown by the directed scenarios that observe the ports:
- The exact pass lengths 16 down to 1 across a full pyramid.
- The reload to a full 0-to-15 pass afterwards.
- A clear that wins over a simultaneous enable.
- A pause that lands exactly on the terminal value.

// File: rtl/pyr_pkg.sv
`timescale 1ns/1ps
package pyr_pkg;

    parameter int PYR_WIDTH = 4;

    // action taken by the counter on the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_ADVANCE = 2'd1,
        ACT_WRAP    = 2'd2,
        ACT_CLEAR   = 2'd3
    } pyr_act_e;

endpackage

// File: rtl/pyr_compare.sv
`timescale 1ns/1ps
module pyr_compare #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] lim,
    output logic             at_limit,
    output logic             cnt_zero,
    output logic             lim_zero
);

    always_comb begin
        at_limit = (cnt == lim);
        cnt_zero = (cnt == '0);
        lim_zero = (lim == '0);
    end

endmodule

// File: rtl/pyr_act_decode.sv
`timescale 1ns/1ps
module pyr_act_decode
    import pyr_pkg::*;
(
    input  logic     clr,
    input  logic     en,
    input  logic     at_limit,
    output pyr_act_e act
);

    always_comb begin
        unique casez ({clr, en, at_limit})
            3'b1??:  act = ACT_CLEAR;
            3'b00?:  act = ACT_HOLD;
            3'b010:  act = ACT_ADVANCE;
            3'b011:  act = ACT_WRAP;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/pyr_limit_next.sv
`timescale 1ns/1ps
module pyr_limit_next #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] lim,
    input  logic             lim_zero,
    output logic [WIDTH-1:0] lim_after_pass
);

    localparam logic [WIDTH-1:0] LIM_TOP = {WIDTH{1'b1}};

    always_comb begin
        case (lim_zero)
            1'b1:    lim_after_pass = LIM_TOP;
            default: lim_after_pass = lim - 1'b1;
        endcase
    end

endmodule

// File: rtl/pyramid_counter.sv
`timescale 1ns/1ps
module pyramid_counter
    import pyr_pkg::*;
#(
    parameter int WIDTH = PYR_WIDTH
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] count_o,
    output logic             pass_end_o,
    output logic             step_one_o
);

    localparam logic [WIDTH-1:0] LIM_TOP = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] lim;
        logic             pass_end;
        logic             step_one;
    } pyr_state_t;

    pyr_state_t st_d, st_q;

    logic             at_limit, cnt_zero, lim_zero;
    logic [WIDTH-1:0] lim_after_pass;
    logic [WIDTH-1:0] lim_q;
    pyr_act_e         act;

    pyr_compare #(.WIDTH(WIDTH)) u_cmp (
        .cnt      (st_q.cnt),
        .lim      (st_q.lim),
        .at_limit (at_limit),
        .cnt_zero (cnt_zero),
        .lim_zero (lim_zero)
    );

    pyr_act_decode u_dec (
        .clr      (clr),
        .en       (en),
        .at_limit (at_limit),
        .act      (act)
    );

    pyr_limit_next #(.WIDTH(WIDTH)) u_lim (
        .lim            (st_q.lim),
        .lim_zero       (lim_zero),
        .lim_after_pass (lim_after_pass)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_CLEAR: begin
                st_d.cnt      = '0;
                st_d.lim      = LIM_TOP;
                st_d.pass_end = 1'b0;
                st_d.step_one = 1'b0;
            end
            ACT_WRAP: begin
                st_d.cnt      = '0;
                st_d.lim      = lim_after_pass;
                st_d.pass_end = 1'b1;
                st_d.step_one = 1'b0;
            end
            ACT_ADVANCE: begin
                st_d.cnt      = st_q.cnt + 1'b1;
                st_d.pass_end = 1'b0;
                st_d.step_one = cnt_zero;
            end
            default: begin
                st_d.pass_end = 1'b0;
                st_d.step_one = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count_o    = st_q.cnt;
    assign pass_end_o = st_q.pass_end;
    assign step_one_o = st_q.step_one;
    assign lim_q      = st_q.lim;

endmodule

// File: rtl/pyramid_counter_chk.sv
`timescale 1ns/1ps
module pyramid_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr,
    input logic             en,
    input logic [WIDTH-1:0] count_o,
    input logic             pass_end_o,
    input logic             step_one_o,
    input logic [WIDTH-1:0] lim_q
);

    localparam logic [WIDTH-1:0] LIM_TOP = {WIDTH{1'b1}};

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
        count_o <= lim_q); // R3

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (clr)
        (en && count_o != lim_q) |=> (count_o == WIDTH'($past(count_o) + 1'b1) && !pass_end_o)); // R3

    AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (clr)
        (en && count_o == lim_q) |=> (count_o == '0 && pass_end_o)); // R4

    AST_LIMIT_DROP: assert property (@(posedge clk) disable iff (clr)
        (en && count_o == lim_q && lim_q != '0) |=> (lim_q == WIDTH'($past(lim_q) - 1'b1))); // R5

    AST_LIMIT_RELOAD: assert property (@(posedge clk) disable iff (clr)
        (en && lim_q == '0) |=> (lim_q == LIM_TOP)); // R6

    AST_STEP_ONE_MARK: assert property (@(posedge clk) disable iff (clr)
        step_one_o |-> (count_o == WIDTH'(1) && $past(count_o) == '0)); // R7

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (clr)
        !en |=> ($stable(count_o) && $stable(lim_q) && !pass_end_o && !step_one_o)); // R8

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (clr)
        (en && lim_q == '0) |=> (count_o == '0 && !step_one_o)); // R9

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (clr)
        !(pass_end_o && step_one_o)); // R10

endmodule

bind pyramid_counter pyramid_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .clr        (clr),
    .en         (en),
    .count_o    (count_o),
    .pass_end_o (pass_end_o),
    .step_one_o (step_one_o),
    .lim_q      (lim_q)
);

// File: tb/test_pyramid_counter.sv
`timescale 1ns/1ps
module test_pyramid_counter;

    localparam int W    = 4;
    localparam int MAXV = 15;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] count_o;
    logic         pass_end_o;
    logic         step_one_o;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    // reference state built from the requirements
    int m_cnt = 0;
    int m_lim = MAXV;
    bit m_p1  = 0;
    bit m_p2  = 0;

    always #5 clk = ~clk;

    pyramid_counter #(.WIDTH(W)) i_pyramid_counter (
        .clk        (clk),
        .clr        (clr),
        .en         (en),
        .count_o    (count_o),
        .pass_end_o (pass_end_o),
        .step_one_o (step_one_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(bit c, bit e);
        if (c) begin
            m_cnt = 0; m_lim = MAXV; m_p1 = 0; m_p2 = 0;
        end else if (e) begin
            if (m_cnt == m_lim) begin
                m_cnt = 0; m_p1 = 1; m_p2 = 0;
                m_lim = (m_lim == 0) ? MAXV : m_lim - 1;
            end else begin
                m_p2  = (m_cnt == 0);
                m_cnt = m_cnt + 1;
                m_p1  = 0;
            end
        end else begin
            m_p1 = 0; m_p2 = 0;
        end
    endtask

    // drive at the falling edge, pass one rising edge, sample at the next falling edge
    task automatic tick(bit c, bit e);
        clr = c;
        en  = e;
        @(posedge clk);
        model_edge(c, e);
        @(negedge clk);
    endtask

    task automatic compare(string req);
        chk(req, int'(count_o), m_cnt);
        chk(req, int'(pass_end_o), int'(m_p1));
        chk(req, int'(step_one_o), int'(m_p2));
        chk("R10", int'(pass_end_o && step_one_o), 0);
    endtask

    task automatic t_reset();
        tick(1, 0);
        tick(1, 1);
        chk("R1 count", int'(count_o), 0);
        chk("R1 pass_end", int'(pass_end_o), 0);
        chk("R1 step_one", int'(step_one_o), 0);
    endtask

    task automatic t_first_pass();
        for (int i = 1; i <= 16; i++) begin
            tick(0, 1);
            chk((i == 16) ? "R4 wrap" : "R2 first pass", int'(count_o), i % 16);
            chk("R4 pass_end", int'(pass_end_o), (i == 16) ? 1 : 0);
            chk("R7 step_one", int'(step_one_o), (i == 1) ? 1 : 0);
        end
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) tick(0, 1);
        chk("R3 count", int'(count_o), 3);
        for (int i = 0; i < 4; i++) begin
            tick(0, 0);
            chk("R8 hold count", int'(count_o), 3);
            chk("R8 hold pass_end", int'(pass_end_o), 0);
            chk("R8 hold step_one", int'(step_one_o), 0);
        end
        while (m_cnt != m_lim) begin
            tick(0, 1);
            compare("R3");
        end
        chk("R8 limit kept", int'(count_o), 14);
        tick(0, 0);
        tick(0, 0);
        chk("R8 parked at limit", int'(count_o), 14);
        chk("R8 no strobe parked", int'(pass_end_o), 0);
        tick(0, 1);
        chk("R4 wrap after pause", int'(count_o), 0);
        chk("R4 strobe after pause", int'(pass_end_o), 1);
        tick(0, 0);
        chk("R8 strobe drops when idle", int'(pass_end_o), 0);
        chk("R8 count stays", int'(count_o), 0);
        tick(0, 1);
        chk("R7 step_one after pause", int'(step_one_o), 1);
        chk("R7 count one", int'(count_o), 1);
    endtask

    task automatic t_pyramid();
        int pass_len;
        int pass_idx;
        tick(1, 0);
        pass_len = 0;
        pass_idx = 0;
        for (int i = 1; i <= 136; i++) begin
            tick(0, 1);
            compare("R5");
            pass_len++;
            if (pass_end_o === 1'b1) begin
                chk("R5 pass length", pass_len, 16 - pass_idx);
                pass_idx++;
                pass_len = 0;
            end
            if (i == 135) begin
                chk("R9 end of limit-1 pass", int'(pass_end_o), 1);
            end
            if (i == 136) begin
                chk("R9 zero pass count", int'(count_o), 0);
                chk("R9 zero pass strobe", int'(pass_end_o), 1);
                chk("R9 zero pass no step_one", int'(step_one_o), 0);
            end
        end
        chk("R5 number of passes", pass_idx, 16);
        for (int i = 1; i <= 16; i++) begin
            tick(0, 1);
            compare("R6");
            chk("R6 reload pass count", int'(count_o), i % 16);
        end
        chk("R6 reload pass wrap", int'(pass_end_o), 1);
    endtask

    task automatic t_mid_clear();
        for (int i = 0; i < 5; i++) tick(0, 1);
        tick(1, 1);
        chk("R1 clear beats enable", int'(count_o), 0);
        chk("R1 clear strobe", int'(pass_end_o), 0);
        for (int i = 1; i <= 16; i++) begin
            tick(0, 1);
            compare("R1");
        end
        chk("R1 full pass after clear", int'(pass_end_o), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_first_pass();
        t_hold();
        t_pyramid();
        t_mid_clear();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule